// File: doc/BRIEF.md
# Buffered Serial Transmitter with Per-Byte Wakeup Bit

This block turns bytes from a host into asynchronous serial frames on a single output line. Bytes enter through a valid/ready stream and wait in a four-entry FIFO. Each byte carries its own wakeup flag. A frame sequencer takes one byte at a time and drives a frame on `txd`. The frame has a low start bit, then eight data bits with the least significant bit first. After the data come an optional wakeup bit, an optional parity bit, and one or two high stop bits.

The pace comes from `baud_tick`, a one-cycle strobe from an external divider. Each bit is held for sixteen ticks. A new frame is launched only when the peer allows it, that is when `cts_n` is low. A frame that has already started always runs to its end.

Back-pressure rules: `in_ready` is high whenever the FIFO holds fewer than four bytes. A byte is taken on a clock edge where both `in_valid` and `in_ready` are high. A byte offered while `in_ready` is low is not held for a later cycle. It is discarded, and the sticky `overflow` flag is raised. The four frame options are read from the `cfg_*` pins once, when each frame is launched.

Top module: `serial_tx_wk`

## Requirements
- R1: Out of reset, `txd` is high, `tx_empty` is high, `in_ready` is high and `overflow` is low. `txd` stays high whenever no frame is in progress.
- R2: Each frame begins with one low start bit. The eight data bits follow, least significant bit first.
- R3: When `cfg_wake_en` is 1, one bit equal to the byte's own `in_wake` value follows the data bits. When it is 0, no bit is inserted.
- R4: When `cfg_par_en` is 1, a parity bit follows the data bits (and the wakeup bit, if present). Parity covers the eight data bits only. `cfg_par_odd`=0 gives an even count of ones over data plus parity; `cfg_par_odd`=1 gives an odd count.
- R5: The frame ends with one high stop bit, or two when `cfg_two_stop` is 1.
- R6: Once a frame has started, `txd` changes only on a cycle with `baud_tick` high. Every bit after the start bit lasts exactly 16 ticks. The start bit ends on the 16th tick after launch.
- R7: The FIFO holds up to four bytes and sends them in the order they were accepted.
- R8: A byte offered while `in_ready` is low is dropped and sets `overflow`, which stays high until reset.
- R9: A frame is launched only while `cts_n` is low and the FIFO is non-empty. A frame in progress completes even if `cts_n` goes high.
- R10: `tx_empty` is high exactly when the FIFO is empty and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pacing strobe, 16 per bit |
| cts_n | input | 1 | Clear to send, active low; gates the launch of a frame |
| cfg_wake_en | input | 1 | Insert a wakeup bit |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_wake | input | 1 | Wakeup bit value for this byte |
| in_ready | output | 1 | FIFO can accept a byte |
| txd | output | 1 | Serial output, idles high |
| tx_empty | output | 1 | FIFO empty and line idle |
| overflow | output | 1 | Sticky flag: a byte was dropped |

## Verification
The assertions check on every cycle that the FIFO never exceeds its depth and that a dropped offer raises `overflow`, which then never falls. They also check that the line is high outside a frame, that a launch follows a cycle with `cts_n` low, and that `txd` never moves mid-frame without a tick. Some behaviour only the bench's scenarios can show. This includes the bit order and values inside whole frames, the parity and wakeup values for each option, the stop bit count and the sixteen-tick bit width. It also includes the order of FIFO drain after an overflow and a frame finishing after `cts_n` is withdrawn.

// File: rtl/serial_tx_wk_pkg.sv
package serial_tx_wk_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_WAKE,
    PH_PARITY,
    PH_STOP
  } tx_phase_e;

  typedef struct packed {
    logic wake_en;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;

  typedef struct packed {
    logic              wake;
    logic [BYTE_W-1:0] data;
  } tx_word_t;
endpackage

// File: rtl/serial_tx_wk_fifo.sv
module serial_tx_wk_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_word,
  input  logic             pop,
  output logic [WIDTH-1:0] head_word,
  output logic             not_empty,
  output logic             not_full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] fill_q;

  assign not_empty = (fill_q != '0);
  assign not_full  = (fill_q != CNT_W'(DEPTH));
  assign head_word = slot_q[rd_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      case ({push, pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_q == PTR_W'(g)) slot_q[g] <= push_word;
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH)); // R7
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty); // R7
endmodule

// File: rtl/serial_tx_wk_seq.sv
module serial_tx_wk_seq
  import serial_tx_wk_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       cts_n,
  input  frame_cfg_t cfg,
  input  logic       word_valid,
  input  tx_word_t   word,
  output logic       word_pop,
  output logic       txd,
  output logic       busy
);
  localparam int unsigned TICK_W = $clog2(OVERSAMPLE);
  localparam int unsigned IDX_W  = $clog2(BYTE_W);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(BYTE_W - 1);

  tx_phase_e         phase_q;
  logic [TICK_W-1:0] tick_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] shift_q;
  logic              wake_q, par_q, stop2_q, txd_q;
  frame_cfg_t        cfg_q;
  logic              bit_done;

  assign busy     = (phase_q != PH_IDLE);
  assign txd      = txd_q;
  assign word_pop = !busy && word_valid && !cts_n;
  assign bit_done = busy && baud_tick && (tick_q == TICK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tick_q  <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      wake_q  <= 1'b0;
      par_q   <= 1'b0;
      stop2_q <= 1'b0;
      txd_q   <= 1'b1;
      cfg_q   <= '0;
    end else if (word_pop) begin
      phase_q <= PH_START;
      tick_q  <= '0;
      idx_q   <= '0;
      shift_q <= word.data;
      wake_q  <= word.wake;
      par_q   <= (^word.data) ^ cfg.par_odd;
      stop2_q <= 1'b0;
      cfg_q   <= cfg;
      txd_q   <= 1'b0;
    end else if (busy && baud_tick) begin
      tick_q <= bit_done ? '0 : tick_q + 1'b1;
      if (bit_done) begin
        unique case (phase_q)
          PH_START: begin
            phase_q <= PH_DATA;
            txd_q   <= shift_q[0];
          end
          PH_DATA: begin
            if (idx_q != IDX_LAST) begin
              idx_q   <= idx_q + 1'b1;
              shift_q <= shift_q >> 1;
              txd_q   <= shift_q[1];
            end else if (cfg_q.wake_en) begin
              phase_q <= PH_WAKE;
              txd_q   <= wake_q;
            end else if (cfg_q.par_en) begin
              phase_q <= PH_PARITY;
              txd_q   <= par_q;
            end else begin
              phase_q <= PH_STOP;
              txd_q   <= 1'b1;
            end
          end
          PH_WAKE: begin
            if (cfg_q.par_en) begin
              phase_q <= PH_PARITY;
              txd_q   <= par_q;
            end else begin
              phase_q <= PH_STOP;
              txd_q   <= 1'b1;
            end
          end
          PH_PARITY: begin
            phase_q <= PH_STOP;
            txd_q   <= 1'b1;
          end
          PH_STOP: begin
            if (cfg_q.two_stop && !stop2_q) begin
              stop2_q <= 1'b1;
            end else begin
              phase_q <= PH_IDLE;
            end
            txd_q <= 1'b1;
          end
          default: begin
            phase_q <= PH_IDLE;
            txd_q   <= 1'b1;
          end
        endcase
      end
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1
  AST_LAUNCH_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cts_n)); // R9
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(txd)); // R6
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2
endmodule

// File: rtl/serial_tx_wk.sv
module serial_tx_wk
  import serial_tx_wk_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cts_n,
  input  logic              cfg_wake_en,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_wake,
  output logic              in_ready,
  output logic              txd,
  output logic              tx_empty,
  output logic              overflow
);
  localparam int unsigned WORD_W = $bits(tx_word_t);

  tx_word_t   in_word, head;
  frame_cfg_t cfg;
  logic       has_word, pop, busy, ovf_q;

  assign in_word = '{wake: in_wake, data: in_data};
  assign cfg     = '{wake_en: cfg_wake_en, par_en: cfg_par_en,
                     par_odd: cfg_par_odd, two_stop: cfg_two_stop};

  serial_tx_wk_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid && in_ready),
    .push_word (in_word),
    .pop       (pop),
    .head_word (head),
    .not_empty (has_word),
    .not_full  (in_ready)
  );

  serial_tx_wk_seq #(.OVERSAMPLE(OVERSAMPLE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .cts_n      (cts_n),
    .cfg        (cfg),
    .word_valid (has_word),
    .word       (head),
    .word_pop   (pop),
    .txd        (txd),
    .busy       (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovf_q <= 1'b0;
    else if (in_valid && !in_ready) ovf_q <= 1'b1;
  end

  assign overflow = ovf_q;
  assign tx_empty = !has_word && !busy;

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && in_ready)); // R10
endmodule

// File: tb/serial_tx_wk_bench.sv
module serial_tx_wk_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CYC    = 16 * TICK_DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cts_n = 1'b1;
  logic cfg_wake_en = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic in_valid = 1'b0, in_wake = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, txd, tx_empty, overflow;
  logic baud_tick;
  logic [1:0] div_q;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0; else div_q <= div_q + 2'd1;
  assign baud_tick = (div_q == 2'd0);

  serial_tx_wk u_serial_tx_wk (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cts_n(cts_n),
    .cfg_wake_en(cfg_wake_en), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .in_valid(in_valid), .in_data(in_data), .in_wake(in_wake),
    .in_ready(in_ready), .txd(txd), .tx_empty(tx_empty), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FIFO? no: FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic w, output bit acc);
    in_valid = 1'b1; in_data = d; in_wake = w;
    acc = in_ready;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic void build(input logic [7:0] d, input logic w,
                                output logic [12:0] b, output int n);
    b = '0; n = 0;
    b[n] = 1'b0; n++;
    for (int i = 0; i < 8; i++) begin b[n] = d[i]; n++; end
    if (cfg_wake_en) begin b[n] = w; n++; end
    if (cfg_par_en) begin b[n] = (^d) ^ cfg_par_odd; n++; end
    b[n] = 1'b1; n++;
    if (cfg_two_stop) begin b[n] = 1'b1; n++; end
  endfunction

  // Waits for a start bit, then samples each bit at three points
  task automatic rx_frame(input int nbits, output logic [12:0] bits, output bit steady);
    int pos;
    logic s0, s1, s2;
    bits = '0; steady = 1'b1; pos = 0;
    while (txd !== 1'b0) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      repeat (BIT_CYC * i + 2 - pos) @(negedge clk);
      s0 = txd;
      repeat (30) @(negedge clk);
      s1 = txd;
      repeat (22) @(negedge clk);
      s2 = txd;
      pos = BIT_CYC * i + 54;
      bits[i] = s1;
      if (s0 !== s1 || s1 !== s2) steady = 1'b0;
    end
  endtask

  task automatic send_and_check(input logic [7:0] d, input logic w, input string req);
    logic [12:0] exp_b, got_b;
    int n;
    bit acc, steady;
    build(d, w, exp_b, n);
    push(d, w, acc);
    rx_frame(n, got_b, steady);
    chk(got_b === exp_b, req, 32'(got_b), 32'(exp_b));
    chk(steady, "R6 bit held 16 ticks", 32'(steady), 32'd1);
    chk(tx_empty === 1'b0, "R10 busy during last stop", 32'(tx_empty), 32'd0);
    repeat (12) @(negedge clk);
    chk(tx_empty === 1'b1 && txd === 1'b1, "R10 empty after stop",
        32'({tx_empty, txd}), 32'b11);
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1 txd idle", 32'(txd), 32'd1);
    chk(tx_empty === 1'b1, "R1 tx_empty", 32'(tx_empty), 32'd1);
    chk(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    chk(overflow === 1'b0, "R1 overflow", 32'(overflow), 32'd0);
  endtask

  task automatic t_plain;
    cfg_wake_en = 0; cfg_par_en = 0; cfg_two_stop = 0; cts_n = 0;
    send_and_check(8'hA5, 1'b1, "R2 R5 plain frame");
    send_and_check(8'h01, 1'b0, "R2 lsb first");
  endtask

  task automatic t_wake_parity;
    cfg_wake_en = 1; cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 1;
    send_and_check(8'h3C, 1'b1, "R3 R4 R5 wake even two stop");
    cfg_par_odd = 1; cfg_two_stop = 0;
    send_and_check(8'h07, 1'b0, "R3 R4 wake0 odd parity");
    cfg_wake_en = 0; cfg_par_odd = 0;
    send_and_check(8'h0B, 1'b1, "R4 even parity no wake");
    cfg_wake_en = 1; cfg_par_en = 0;
    send_and_check(8'hF0, 1'b1, "R3 wake without parity");
  endtask

  task automatic t_cts;
    logic [12:0] exp_b, got_b;
    int n;
    bit acc, steady, quiet;
    cfg_wake_en = 0; cfg_par_en = 0; cfg_two_stop = 0; cts_n = 1;
    push(8'h11, 1'b0, acc);
    push(8'h22, 1'b0, acc);
    quiet = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) quiet = 0;
    end
    chk(quiet, "R9 no launch with cts_n high", 32'(quiet), 32'd1);
    chk(tx_empty === 1'b0, "R10 queued not empty", 32'(tx_empty), 32'd0);
    cts_n = 0;
    build(8'h11, 1'b0, exp_b, n);
    fork
      rx_frame(n, got_b, steady);
      begin repeat (100) @(negedge clk); cts_n = 1; end
    join
    chk(got_b === exp_b, "R9 frame completes after cts_n rises", 32'(got_b), 32'(exp_b));
    quiet = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) quiet = 0;
    end
    chk(quiet, "R9 second byte held back", 32'(quiet), 32'd1);
    cts_n = 0;
    build(8'h22, 1'b0, exp_b, n);
    rx_frame(n, got_b, steady);
    chk(got_b === exp_b, "R9 second byte after cts_n", 32'(got_b), 32'(exp_b));
    repeat (12) @(negedge clk);
  endtask

  task automatic t_overflow;
    logic [12:0] exp_b, got_b;
    logic [7:0] vals [5];
    int n;
    bit acc, steady;
    vals = '{8'h5A, 8'hC3, 8'h81, 8'h7E, 8'hEE};
    cfg_wake_en = 0; cfg_par_en = 0; cfg_two_stop = 0; cts_n = 1;
    for (int i = 0; i < 4; i++) begin
      push(vals[i], 1'b0, acc);
      chk(acc, "R7 accept while room", 32'(acc), 32'd1);
    end
    chk(overflow === 1'b0, "R8 no overflow yet", 32'(overflow), 32'd0);
    push(vals[4], 1'b0, acc);
    chk(!acc, "R7 in_ready low when full", 32'(acc), 32'd0);
    chk(overflow === 1'b1, "R8 overflow set", 32'(overflow), 32'd1);
    cts_n = 0;
    for (int i = 0; i < 4; i++) begin
      build(vals[i], 1'b0, exp_b, n);
      rx_frame(n, got_b, steady);
      chk(got_b === exp_b, "R7 R8 order, dropped byte absent", 32'(got_b), 32'(exp_b));
    end
    repeat (12) @(negedge clk);
    chk(tx_empty === 1'b1, "R8 dropped byte never sent", 32'(tx_empty), 32'd1);
    chk(overflow === 1'b1, "R8 overflow sticky", 32'(overflow), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_wake_parity();
    t_cts();
    t_overflow();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule